// File: doc/BRIEF.md
# Trim Command Range and Slew Limiter

This block conditions a stream of signed trim commands on their way to an engine or inlet controller. Once per control frame, marked by a one-cycle frame strobe, it takes a new command. It limits the command to a programmable window that is always inside a fixed magnitude ceiling. It then moves its registered output toward that target by no more than a programmable step. The output is registered and changes only on a frame strobe.

Two conditions take priority over the tracking path. A detected failure cancels the trim and drives the output to zero. Otherwise, an active override loads a caller-supplied safe value directly. When neither is present the window clamp and the slew limit apply, in that order. Because a cancelled output sits at zero, the output climbs back toward the command at the step rate after the failure clears, with no jump.

A range flag reports every command that falls outside the effective window, so that an integrity monitor can uncouple the system. A second flag marks frames in which the slew limit cut the move short.

Top module: `trim_lim_core`

## Requirements
- R1: While reset is asserted, and after reset is released until the first frame strobe, `trim_out` is 0 and both flags are 0.
- R2: Outputs change only on a clock edge at which `frame_tick` is 1. On every other cycle all three outputs hold their values.
- R3: On a frame with `fail_in` = 1, `trim_out` becomes 0 and `rate_limited` becomes 0, whatever the other inputs are.
- R4: On a frame with `fail_in` = 0 and `ovr_en` = 1, `trim_out` becomes `ovr_val` exactly and `rate_limited` becomes 0. No clamp or slew applies.
- R5: The effective upper bound is the smaller of `lim_hi` and +MAG_MAX. The effective lower bound is the larger of `lim_lo` and −MAG_MAX. MAG_MAX defaults to 1280, which is ±5 degrees at 1/256 degree per LSB. The tracking target is the command clamped to these bounds.
- R6: On every frame, `range_fault` becomes 1 if `cmd_in` is above the effective upper bound or below the effective lower bound, and 0 otherwise. This holds regardless of `fail_in` and `ovr_en`.
- R7: On a tracking frame (no failure, no override), let d be the target minus the previous output. If |d| > `step_max`, the output moves by exactly `step_max` toward the target and `rate_limited` becomes 1. Otherwise the output becomes the target and `rate_limited` becomes 0.
- R8: After a failure clears, the output leaves zero and approaches the target by `step_max` per frame.
- R9: All values are 16-bit two's complement, except `step_max`, which is unsigned. The difference and step arithmetic never wraps, even when the previous output is at −32768 or +32767 and the step is 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle strobe that marks a control frame |
| cmd_in | input | 16 | Signed trim command |
| lim_hi | input | 16 | Signed programmable upper bound |
| lim_lo | input | 16 | Signed programmable lower bound |
| step_max | input | 16 | Unsigned largest change per frame |
| fail_in | input | 1 | Failure detected: cancel the trim to zero |
| ovr_en | input | 1 | Load the override value |
| ovr_val | input | 16 | Signed safe value used while overriding |
| trim_out | output | 16 | Signed limited trim command |
| range_fault | output | 1 | Command was outside the effective bounds on the last frame |
| rate_limited | output | 1 | Slew limit was applied on the last frame |

## Verification
Two things can happen on the same frame. First, the range flag can be raised while a failure or override decides the output; here the flag must still follow the command, and the output must follow the priority path. Second, the window clamp and the slew limit can both act on one move; here the output must step toward the clamped target, not toward the raw command. The sweep interleaves failures and overrides with large alternating commands across several window and step settings, so that both pairings occur many times. An arithmetic model predicts each frame's output and both flags, and every frame is compared against it.

// File: rtl/trim_lim_pkg.sv
`timescale 1ns/1ps
package trim_lim_pkg;

  typedef enum logic [1:0] {
    PATH_TRACK  = 2'd0,
    PATH_FORCE  = 2'd1,
    PATH_CANCEL = 2'd2
  } trim_path_e;

  typedef struct packed {
    logic range_bad;
    logic slew_hit;
  } trim_flags_t;

endpackage

// File: rtl/trim_lim_bound.sv
`timescale 1ns/1ps
module trim_lim_bound #(
  parameter int W       = 16,
  parameter int MAG_MAX = 1280
) (
  input  logic signed [W-1:0] cmd,
  input  logic signed [W-1:0] hi_req,
  input  logic signed [W-1:0] lo_req,
  output logic signed [W-1:0] target,
  output logic                out_of_range
);
  localparam logic signed [W-1:0] MAG_POS = W'(MAG_MAX);
  localparam logic signed [W-1:0] MAG_NEG = -MAG_POS;

  logic signed [W-1:0] hi_eff;
  logic signed [W-1:0] lo_eff;
  logic                above;
  logic                below;

  always_comb begin
    hi_eff = (hi_req > MAG_POS) ? MAG_POS : hi_req;
    lo_eff = (lo_req < MAG_NEG) ? MAG_NEG : lo_req;
    above  = (cmd > hi_eff);
    below  = (cmd < lo_eff);
    if (above)      target = hi_eff;
    else if (below) target = lo_eff;
    else            target = cmd;
    out_of_range = above | below;
  end
endmodule

// File: rtl/trim_lim_slew.sv
`timescale 1ns/1ps
module trim_lim_slew #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] prev,
  input  logic signed [W-1:0] target,
  input  logic        [W-1:0] step,
  output logic signed [W-1:0] next,
  output logic                limited
);
  localparam int XW = W + 2;

  logic signed [XW-1:0] prev_x;
  logic signed [XW-1:0] tgt_x;
  logic signed [XW-1:0] stp_x;
  logic signed [XW-1:0] delta;
  logic signed [XW-1:0] moved;

  always_comb begin
    prev_x  = {{2{prev[W-1]}}, prev};
    tgt_x   = {{2{target[W-1]}}, target};
    stp_x   = {2'b00, step};
    delta   = tgt_x - prev_x;
    moved   = tgt_x;
    limited = 1'b0;
    if (delta > stp_x) begin
      moved   = prev_x + stp_x;
      limited = 1'b1;
    end else if (delta < -stp_x) begin
      moved   = prev_x - stp_x;
      limited = 1'b1;
    end
    next = moved[W-1:0];
  end
endmodule

// File: rtl/trim_lim_select.sv
`timescale 1ns/1ps
module trim_lim_select
  import trim_lim_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                fail,
  input  logic                force_en,
  input  logic signed [W-1:0] force_val,
  input  logic signed [W-1:0] track_val,
  input  logic                track_limited,
  output logic signed [W-1:0] sel_val,
  output logic                sel_limited
);
  trim_path_e path;

  always_comb begin
    if (fail)          path = PATH_CANCEL;
    else if (force_en) path = PATH_FORCE;
    else               path = PATH_TRACK;
    case (path)
      PATH_CANCEL: begin sel_val = '0;        sel_limited = 1'b0;          end
      PATH_FORCE:  begin sel_val = force_val; sel_limited = 1'b0;          end
      default:     begin sel_val = track_val; sel_limited = track_limited; end
    endcase
  end
endmodule

// File: rtl/trim_lim_core.sv
`timescale 1ns/1ps
module trim_lim_core
  import trim_lim_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAG_MAX = 1280,
  parameter int SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [W-1:0]  cmd_in,
  input  logic [W-1:0]  lim_hi,
  input  logic [W-1:0]  lim_lo,
  input  logic [W-1:0]  step_max,
  input  logic          fail_in,
  input  logic          ovr_en,
  input  logic [W-1:0]  ovr_val,
  output logic [W-1:0]  trim_out,
  output logic          range_fault,
  output logic          rate_limited
);
  logic [SYNC_N-1:0] sync_q;
  logic              rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ok = sync_q[SYNC_N-1];

  logic signed [W-1:0] out_q, out_d;
  trim_flags_t         flg_q, flg_d;

  logic signed [W-1:0] target;
  logic                oor;
  logic signed [W-1:0] slew_next;
  logic                slew_lim;
  logic signed [W-1:0] sel_val;
  logic                sel_lim;

  trim_lim_bound #(.W(W), .MAG_MAX(MAG_MAX)) u_bound (
    .cmd          ($signed(cmd_in)),
    .hi_req       ($signed(lim_hi)),
    .lo_req       ($signed(lim_lo)),
    .target       (target),
    .out_of_range (oor)
  );

  trim_lim_slew #(.W(W)) u_slew (
    .prev    (out_q),
    .target  (target),
    .step    (step_max),
    .next    (slew_next),
    .limited (slew_lim)
  );

  trim_lim_select #(.W(W)) u_sel (
    .fail          (fail_in),
    .force_en      (ovr_en),
    .force_val     ($signed(ovr_val)),
    .track_val     (slew_next),
    .track_limited (slew_lim),
    .sel_val       (sel_val),
    .sel_limited   (sel_lim)
  );

  always_comb begin
    out_d = out_q;
    flg_d = flg_q;
    if (frame_tick) begin
      out_d          = sel_val;
      flg_d.range_bad = oor;
      flg_d.slew_hit  = sel_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_q <= '0;
      flg_q <= '0;
    end else begin
      out_q <= out_d;
      flg_q <= flg_d;
    end
  end

  assign trim_out     = out_q;
  assign range_fault  = flg_q.range_bad;
  assign rate_limited = flg_q.slew_hit;
endmodule

// File: rtl/trim_lim_checker.sv
`timescale 1ns/1ps
module trim_lim_checker #(
  parameter int W       = 16,
  parameter int MAG_MAX = 1280
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         frame_tick,
  input logic         fail_in,
  input logic         ovr_en,
  input logic [W-1:0] ovr_val,
  input logic [W-1:0] step_max,
  input logic [W-1:0] trim_out,
  input logic         range_fault,
  input logic         rate_limited
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAGX = XW'(MAG_MAX);

  logic signed [XW-1:0] out_x;
  logic signed [XW-1:0] stp_x;
  assign out_x = {{2{trim_out[W-1]}}, trim_out};
  assign stp_x = {2'b00, step_max};

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_ok)
    !frame_tick |=> $stable(trim_out) && $stable(range_fault) && $stable(rate_limited)); // R2

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_tick && fail_in |=> (trim_out == '0) && !rate_limited); // R3

  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_tick && !fail_in && ovr_en |=> (trim_out == $past(ovr_val)) && !rate_limited); // R4

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_tick && !fail_in && !ovr_en |=>
      ((out_x - $past(out_x)) <= $past(stp_x)) && (($past(out_x) - out_x) <= $past(stp_x))); // R7

  AST_FLAG_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_tick && !fail_in && !ovr_en |=> !rate_limited ||
      ((out_x - $past(out_x)) == $past(stp_x)) || (($past(out_x) - out_x) == $past(stp_x))); // R7

  AST_MAG_KEPT: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_tick && !fail_in && !ovr_en && (out_x <= MAGX) && (out_x >= -MAGX) |=>
      (out_x <= MAGX) && (out_x >= -MAGX)); // R5
endmodule

bind trim_lim_core trim_lim_checker #(.W(W), .MAG_MAX(MAG_MAX)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .frame_tick   (frame_tick),
  .fail_in      (fail_in),
  .ovr_en       (ovr_en),
  .ovr_val      (ovr_val),
  .step_max     (step_max),
  .trim_out     (trim_out),
  .range_fault  (range_fault),
  .rate_limited (rate_limited)
);

// File: tb/trim_lim_core_bench.sv
`timescale 1ns/1ps
module trim_lim_core_bench;
  localparam int MAG = 1280;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_tick;
  logic [15:0] cmd_in, lim_hi, lim_lo, step_max, ovr_val;
  logic        fail_in, ovr_en;
  logic [15:0] trim_out;
  logic        range_fault, rate_limited;

  int n_cmp = 0;
  int n_bad = 0;
  int m_out = 0;
  int m_rf  = 0;
  int m_rl  = 0;

  always #2 clk = ~clk;

  trim_lim_core u_trim_lim_core (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cmd_in(cmd_in),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .step_max(step_max), .fail_in(fail_in),
    .ovr_en(ovr_en), .ovr_val(ovr_val), .trim_out(trim_out),
    .range_fault(range_fault), .rate_limited(rate_limited)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " out"}, int'($signed(trim_out)), m_out);
    chk({req, " range"}, int'(range_fault), m_rf);
    chk({req, " rate"}, int'(rate_limited), m_rl);
  endtask

  // Arithmetic model of one frame
  task automatic model(input int cmd, input int hi, input int lo, input int stp,
                       input bit fl, input bit ov, input int ovv);
    int heff, leff, tgt, d;
    heff = (hi > MAG) ? MAG : hi;
    leff = (lo < -MAG) ? -MAG : lo;
    m_rf = (cmd > heff || cmd < leff) ? 1 : 0;
    tgt  = (cmd > heff) ? heff : ((cmd < leff) ? leff : cmd);
    if (fl) begin m_out = 0; m_rl = 0; end
    else if (ov) begin m_out = ovv; m_rl = 0; end
    else begin
      d = tgt - m_out;
      if (d > stp)       begin m_out = m_out + stp; m_rl = 1; end
      else if (d < -stp) begin m_out = m_out - stp; m_rl = 1; end
      else               begin m_out = tgt; m_rl = 0; end
    end
  endtask

  task automatic frame(input int cmd, input int hi, input int lo, input int stp,
                       input bit fl, input bit ov, input int ovv, input string req);
    @(negedge clk);
    cmd_in = 16'(cmd); lim_hi = 16'(hi); lim_lo = 16'(lo); step_max = 16'(stp);
    fail_in = fl; ovr_en = ov; ovr_val = 16'(ovv); frame_tick = 1'b1;
    model(cmd, hi, lo, stp, fl, ov, ovv);
    @(negedge clk);
    frame_tick = 1'b0;
    chk_all(req);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; cmd_in = 16'd900; lim_hi = 16'd1000;
    lim_lo = -16'sd1000; step_max = 16'd50; fail_in = 1'b0; ovr_en = 1'b0; ovr_val = 16'd0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // Sweep over window/step configurations; failures and overrides interleaved
    for (int c = 0; c < 4; c++) begin
      int hi, lo, stp;
      case (c)
        0: begin hi = 1000; lo = -1000; stp = 50;   end
        1: begin hi = 2000; lo = -2000; stp = 300;  end
        2: begin hi = 500;  lo = -200;  stp = 7;    end
        default: begin hi = 1280; lo = -1280; stp = 4000; end
      endcase
      for (int k = 0; k < 60; k++) begin
        int v, cmd;
        bit fl, ov;
        v   = k * 59;
        cmd = (k % 2 == 1) ? v - 300 : 300 - v;
        fl  = (k % 13 == 5);
        ov  = (k % 11 == 3) || (k % 17 == 5);
        frame(cmd, hi, lo, stp, fl, ov, k * 37 - 900,
              fl ? "R3 R6 cancel" : (ov ? "R4 R6 force" : "R5 R6 R7 track"));
        // Inputs move without a strobe: nothing may change
        @(negedge clk);
        cmd_in = ~cmd_in; fail_in = ~fl; ovr_en = 1'b1; ovr_val = 16'h1234;
        @(negedge clk);
        chk_all("R2 hold");
      end
    end

    // Recovery ramp from zero after a failure
    frame(1000, 1280, -1280, 100, 1'b1, 1'b0, 0, "R3 cancel");
    for (int k = 0; k < 12; k++) frame(1000, 1280, -1280, 100, 1'b0, 1'b0, 0, "R8 ramp");
    frame(-900, 1280, -1280, 250, 1'b1, 1'b0, 0, "R3 cancel");
    for (int k = 0; k < 5; k++) frame(-900, 1280, -1280, 250, 1'b0, 1'b0, 0, "R8 ramp down");

    // Extreme arithmetic
    frame(0, 1280, -1280, 0, 1'b0, 1'b1, -32768, "R4 force min");
    frame(32767, 32767, -32768, 65535, 1'b0, 1'b0, 0, "R9 wide step");
    frame(0, 1280, -1280, 0, 1'b0, 1'b1, 32767, "R4 force max");
    frame(-32768, 32767, -32768, 0, 1'b0, 1'b0, 0, "R9 zero step");
    frame(-32768, 32767, -32768, 65535, 1'b0, 1'b0, 0, "R9 R5 big drop");
    frame(1281, 32767, -32768, 65535, 1'b0, 1'b0, 0, "R5 R6 ceiling");
    frame(-1280, 32767, -32768, 65535, 1'b0, 1'b0, 0, "R5 R6 floor edge");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule